// File: doc/BRIEF.md
# Intermittent Fault Burst Sequencer

This block plays back one randomized intermittent-resistance fault burst as a stream of wiper codes for a digital potentiometer, plus an enable for the bypass switch that puts that potentiometer in the line. A single start strobe runs one burst. A random start delay comes first. Then come a number of fault events, each an active interval that holds a random resistance code, separated by fault-free gaps. A fault-free safe interval follows, and the block returns to idle with a one-cycle completion pulse. All times are clock cycles.

Each of the six quantities is drawn uniformly from its own programmable low/high pair: start delay, resistance, active length, gap length, event count and safe length. A 32-bit seeded pseudo-random generator supplies the randomness and advances only when a draw is made. Reloading a seed therefore reproduces a burst exactly. The expected set-up scales the default time ranges to cycles, for example a start delay of 10 to 100 units and an event count of 1 to 20.

The controller is a state machine with five states: `PH_IDLE`, `PH_DELAY`, `PH_ACTIVE`, `PH_GAP` and `PH_SAFE`. Its transitions are:

- **launch** goes from `PH_IDLE` to `PH_DELAY` on start.
- **strike** goes from `PH_DELAY` to `PH_ACTIVE`.
- **relax** goes from `PH_ACTIVE` to `PH_GAP` while events remain.
- **again** goes from `PH_GAP` to `PH_ACTIVE`.
- **settle** goes from `PH_ACTIVE` to `PH_SAFE` after the last event.
- **finish** goes from `PH_SAFE` to `PH_IDLE`.

Top module: `irf_burst_seq`

## Requirements
- R1: After reset the block is idle, with `busy`, `fault_on` and `done` low and `res_code` zero.
- R2: A `start` high while idle causes launch, and `busy` is high from the next cycle. A `start` while busy, including in the last safe cycle, has no effect on the running burst and does not begin another.
- R3: The states run delay, then active, then gap and active again for each further event, then safe, then idle. A state entered with a drawn length L lasts L cycles, and a drawn length of 0 lasts one cycle.
- R4: A drawn value is lo + (rotl(W, 5k) mod (hi - lo + 1)). W is the generator word at the draw, rotl is a 32-bit left rotation, and k is 0 for start delay, 1 for resistance, 2 for active length, 3 for gap length, 4 for event count and 5 for safe length. When hi < lo, the value is lo.
- R5: The generator is a right-shifting Galois register that moves from s to s>>1 XOR 32'h80200003 when s[0] is 1, and to s>>1 otherwise. Its reset value is 32'h1D872B41. It steps once at each of the following transitions: launch, strike, relax, again and settle. Launch draws start delay and event count. Strike and again draw active length and resistance. Relax draws gap length and settle draws safe length. All draws at a transition use the word before that step.
- R6: The event count sets the number of active intervals, and a drawn count of 0 is treated as 1. A count of 1 gives a single active interval followed directly by safe.
- R7: In active intervals `fault_on` is 1 and `res_code` holds that interval's drawn resistance. In every other state `fault_on` is 0 and `res_code` is 0, the lowest code.
- R8: `done` is high for exactly one cycle, the first idle cycle after safe, and `busy` is low in that cycle.
- R9: A `seed_load` puts `seed_val` into the generator, with a zero seed replaced by 32'h1D872B41. The same seed gives an identical burst. When `seed_load` and `start` fall in the same cycle, the burst draws from the newly loaded seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst launch strobe |
| seed_load | input | 1 | Load generator seed |
| seed_val | input | 32 | Seed value |
| start_lo | input | TW | Start delay low bound |
| start_hi | input | TW | Start delay high bound |
| res_lo | input | RW | Resistance code low bound |
| res_hi | input | RW | Resistance code high bound |
| act_lo | input | TW | Active length low bound |
| act_hi | input | TW | Active length high bound |
| gap_lo | input | TW | Gap length low bound |
| gap_hi | input | TW | Gap length high bound |
| count_lo | input | BW | Event count low bound |
| count_hi | input | BW | Event count high bound |
| safe_lo | input | TW | Safe length low bound |
| safe_hi | input | TW | Safe length high bound |
| res_code | output | RW | Potentiometer wiper code |
| fault_on | output | 1 | Bypass switch enable (fault applied) |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of functions can meet in one cycle, and each pair is provoked on purpose.

The first pair is the end of the safe interval and a new launch request. The bench raises `start` in exactly the last safe cycle. It then judges the result at the ports: `done` must pulse, `busy` must drop, and `busy` must stay low one cycle later.

The second pair is a seed load and a launch strobe. Both are driven in the same cycle, and the whole burst is compared cycle by cycle against a reference sequence drawn from the new seed. This shows the load wins over the old generator state.

// File: rtl/irf_pkg.sv
package irf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DELAY  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_GAP    = 3'd3,
        PH_SAFE   = 3'd4
    } irf_phase_e;

    // rotation distance between the draw slots of one generator word
    localparam int ROT_STEP = 5;

endpackage

// File: rtl/irf_lfsr.sv
module irf_lfsr #(
    parameter logic [31:0] MASK = 32'h80200003,
    parameter logic [31:0] FIX  = 32'h1D872B41
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        step,
    output logic [31:0] word
);
    logic [31:0] q;
    logic [31:0] base;
    logic [31:0] nxt;

    always_comb begin
        if (load) base = (load_val == 32'd0) ? FIX : load_val;
        else      base = q;
        nxt = base[0] ? ((base >> 1) ^ MASK) : (base >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= FIX;
        else if (step) q <= nxt;
        else           q <= base;
    end

    assign word = base;
endmodule

// File: rtl/irf_span_draw.sv
module irf_span_draw #(
    parameter int W   = 16,
    parameter int ROT = 0
) (
    input  logic [31:0]  word,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] val
);
    logic [31:0] rot;
    logic [W:0]  span;

    generate
        if (ROT == 0) begin : g_plain
            assign rot = word;
        end else begin : g_rot
            assign rot = {word[31-ROT:0], word[31:32-ROT]};
        end
    endgenerate

    always_comb begin
        if (hi >= lo) span = {1'b0, hi} - {1'b0, lo} + {{W{1'b0}}, 1'b1};
        else          span = {{W{1'b0}}, 1'b1};
        val = lo + W'(rot % 32'(span));
    end
endmodule

// File: rtl/irf_burst_seq.sv
module irf_burst_seq
    import irf_pkg::*;
#(
    parameter int          TW        = 16,
    parameter int          RW        = 8,
    parameter int          BW        = 5,
    parameter logic [31:0] LFSR_MASK = 32'h80200003,
    parameter logic [31:0] SEED_FIX  = 32'h1D872B41
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          seed_load,
    input  logic [31:0]   seed_val,
    input  logic [TW-1:0] start_lo,
    input  logic [TW-1:0] start_hi,
    input  logic [RW-1:0] res_lo,
    input  logic [RW-1:0] res_hi,
    input  logic [TW-1:0] act_lo,
    input  logic [TW-1:0] act_hi,
    input  logic [TW-1:0] gap_lo,
    input  logic [TW-1:0] gap_hi,
    input  logic [BW-1:0] count_lo,
    input  logic [BW-1:0] count_hi,
    input  logic [TW-1:0] safe_lo,
    input  logic [TW-1:0] safe_hi,
    output logic [RW-1:0] res_code,
    output logic          fault_on,
    output logic          busy,
    output logic          done
);
    // time-valued draws: 0 start delay, 1 active, 2 gap, 3 safe
    localparam int NT      = 4;
    localparam int TI_STRT = 0;
    localparam int TI_ACT  = 1;
    localparam int TI_GAP  = 2;
    localparam int TI_SAFE = 3;
    localparam int TROT [NT] = '{0, ROT_STEP * 2, ROT_STEP * 3, ROT_STEP * 5};
    localparam int ROT_RES = ROT_STEP * 1;
    localparam int ROT_CNT = ROT_STEP * 4;

    irf_phase_e    ph_q, ph_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [BW-1:0] left_q, left_d;
    logic          step;
    logic          last;
    logic [31:0]   rnd;

    logic [TW-1:0] t_lo  [NT];
    logic [TW-1:0] t_hi  [NT];
    logic [TW-1:0] t_val [NT];
    logic [RW-1:0] res_val;
    logic [BW-1:0] cnt_val;
    logic [BW-1:0] cnt_eff;

    assign t_lo[TI_STRT] = start_lo;  assign t_hi[TI_STRT] = start_hi;
    assign t_lo[TI_ACT]  = act_lo;    assign t_hi[TI_ACT]  = act_hi;
    assign t_lo[TI_GAP]  = gap_lo;    assign t_hi[TI_GAP]  = gap_hi;
    assign t_lo[TI_SAFE] = safe_lo;   assign t_hi[TI_SAFE] = safe_hi;

    irf_lfsr #(.MASK(LFSR_MASK), .FIX(SEED_FIX)) u_rng (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_load),
        .load_val (seed_val),
        .step     (step),
        .word     (rnd)
    );

    generate
        for (genvar g = 0; g < NT; g++) begin : g_tdraw
            irf_span_draw #(.W(TW), .ROT(TROT[g])) u_draw (
                .word (rnd),
                .lo   (t_lo[g]),
                .hi   (t_hi[g]),
                .val  (t_val[g])
            );
        end
    endgenerate

    irf_span_draw #(.W(RW), .ROT(ROT_RES)) u_res_draw (
        .word (rnd), .lo (res_lo), .hi (res_hi), .val (res_val)
    );

    irf_span_draw #(.W(BW), .ROT(ROT_CNT)) u_cnt_draw (
        .word (rnd), .lo (count_lo), .hi (count_hi), .val (cnt_val)
    );

    assign cnt_eff = (cnt_val == '0) ? BW'(1) : cnt_val;
    assign last    = (cnt_q <= TW'(1));

    // next state and interval loads
    always_comb begin
        ph_d   = ph_q;
        cnt_d  = last ? cnt_q : cnt_q - TW'(1);
        left_d = left_q;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin                        // launch
                    ph_d   = PH_DELAY;
                    cnt_d  = t_val[TI_STRT];
                    left_d = cnt_eff;
                end
            end
            PH_DELAY: begin
                if (last) begin                         // strike
                    ph_d  = PH_ACTIVE;
                    cnt_d = t_val[TI_ACT];
                end
            end
            PH_ACTIVE: begin
                if (last) begin
                    if (left_q > BW'(1)) begin          // relax
                        ph_d   = PH_GAP;
                        cnt_d  = t_val[TI_GAP];
                        left_d = left_q - BW'(1);
                    end else begin                      // settle
                        ph_d  = PH_SAFE;
                        cnt_d = t_val[TI_SAFE];
                    end
                end
            end
            PH_GAP: begin
                if (last) begin                         // again
                    ph_d  = PH_ACTIVE;
                    cnt_d = t_val[TI_ACT];
                end
            end
            PH_SAFE: begin
                if (last) ph_d = PH_IDLE;               // finish
            end
            default: ph_d = PH_IDLE;
        endcase
        step = (ph_d != ph_q) && (ph_q != PH_SAFE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            left_q <= '0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            left_q <= left_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_code <= '0;
            fault_on <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            busy     <= (ph_d != PH_IDLE);
            fault_on <= (ph_d == PH_ACTIVE);
            done     <= (ph_q == PH_SAFE) && (ph_d == PH_IDLE);
            if (ph_d == PH_ACTIVE)
                res_code <= (ph_q == PH_ACTIVE) ? res_code : res_val;
            else
                res_code <= '0;
        end
    end
endmodule

// File: rtl/irf_burst_seq_chk.sv
module irf_burst_seq_chk #(
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [RW-1:0] res_code,
    input logic          fault_on,
    input logic          busy,
    input logic          done
);
    a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    a_r7_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_on |-> res_code == '0);

    a_r7_fault_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        fault_on |-> busy);

    a_r7_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        fault_on && $past(fault_on) |-> res_code == $past(res_code));

    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind irf_burst_seq irf_burst_seq_chk #(.RW(RW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .res_code (res_code),
    .fault_on (fault_on),
    .busy     (busy),
    .done     (done)
);

// File: tb/irf_burst_seq_test.sv
`timescale 1ns/1ps
module irf_burst_seq_test;
    localparam int TW = 16;
    localparam int RW = 8;
    localparam int BW = 5;
    localparam logic [31:0] MASK = 32'h80200003;
    localparam logic [31:0] FIX  = 32'h1D872B41;

    // stimulus table: one row per burst configuration
    localparam int NROW = 6;
    // row 0 wide ranges, 1 other seed, 2 single event (R6), 3 twenty events,
    // 4 reversed resistance bounds (R4), 5 zero lengths and zero count (R3, R6)
    localparam int unsigned T_SLO [NROW] = '{3, 1, 5, 2, 1, 0};
    localparam int unsigned T_SHI [NROW] = '{9, 4, 5, 2, 3, 0};
    localparam int unsigned T_RLO [NROW] = '{5, 0, 9, 77, 50, 1};
    localparam int unsigned T_RHI [NROW] = '{200, 255, 9, 77, 10, 254};
    localparam int unsigned T_ALO [NROW] = '{1, 2, 4, 2, 1, 0};
    localparam int unsigned T_AHI [NROW] = '{3, 5, 4, 2, 2, 0};
    localparam int unsigned T_GLO [NROW] = '{1, 1, 1, 1, 1, 0};
    localparam int unsigned T_GHI [NROW] = '{2, 3, 1, 1, 1, 0};
    localparam int unsigned T_CLO [NROW] = '{1, 2, 1, 20, 3, 0};
    localparam int unsigned T_CHI [NROW] = '{20, 6, 1, 20, 3, 0};
    localparam int unsigned T_FLO [NROW] = '{2, 1, 3, 1, 1, 0};
    localparam int unsigned T_FHI [NROW] = '{6, 3, 3, 1, 1, 0};
    localparam logic [31:0] T_SEED [NROW] =
        '{32'h00001234, 32'hDEADBEEF, 32'h00000055, 32'h00000007, 32'h00000063, 32'h0000002A};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          seed_load = 1'b0;
    logic [31:0]   seed_val = '0;
    logic [TW-1:0] start_lo = '0, start_hi = '0, act_lo = '0, act_hi = '0;
    logic [TW-1:0] gap_lo = '0, gap_hi = '0, safe_lo = '0, safe_hi = '0;
    logic [RW-1:0] res_lo = '0, res_hi = '0;
    logic [BW-1:0] count_lo = '0, count_hi = '0;
    logic [RW-1:0] res_code;
    logic          fault_on, busy, done;

    int unsigned checks = 0;
    int unsigned failures = 0;
    int unsigned r_errs;
    longint unsigned r_sig;
    logic [31:0] m;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irf_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load), .seed_val(seed_val),
        .start_lo(start_lo), .start_hi(start_hi), .res_lo(res_lo), .res_hi(res_hi),
        .act_lo(act_lo), .act_hi(act_hi), .gap_lo(gap_lo), .gap_hi(gap_hi),
        .count_lo(count_lo), .count_hi(count_hi), .safe_lo(safe_lo), .safe_hi(safe_hi),
        .res_code(res_code), .fault_on(fault_on), .busy(busy), .done(done)
    );

    function automatic logic [31:0] m_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ MASK) : (s >> 1);
    endfunction

    function automatic int unsigned m_draw(input logic [31:0] s, input int k,
                                           input int unsigned lo, input int unsigned hi);
        logic [31:0] r;
        int unsigned span;
        r = (k == 0) ? s : ((s << (5 * k)) | (s >> (32 - 5 * k)));
        span = (hi >= lo) ? hi - lo + 1 : 1;
        return lo + (r % span);
    endfunction

    function automatic int unsigned atl1(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare one cycle, then drive start for the next edge
    task automatic cyc(input bit eb, input bit ef, input int unsigned er, input bit poke);
        if (busy !== eb || fault_on !== ef || res_code !== RW'(er) || done !== 1'b0) r_errs++;
        r_sig = r_sig * 31 + res_code + (fault_on ? 1000 : 0) + (busy ? 7 : 0);
        start = poke;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        seed_load = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m = FIX;
        @(negedge clk);
    endtask

    task automatic run_burst(input int r, input bit load, input logic [31:0] seed,
                             input bit same, input bit poke);
        int unsigned d, n, a, rc, g, f;
        start_lo = TW'(T_SLO[r]); start_hi = TW'(T_SHI[r]);
        res_lo   = RW'(T_RLO[r]); res_hi   = RW'(T_RHI[r]);
        act_lo   = TW'(T_ALO[r]); act_hi   = TW'(T_AHI[r]);
        gap_lo   = TW'(T_GLO[r]); gap_hi   = TW'(T_GHI[r]);
        count_lo = BW'(T_CLO[r]); count_hi = BW'(T_CHI[r]);
        safe_lo  = TW'(T_FLO[r]); safe_hi  = TW'(T_FHI[r]);
        r_errs = 0;
        r_sig = 0;
        if (load) begin
            seed_load = 1'b1;
            seed_val = seed;
            if (!same) begin
                @(negedge clk);
                seed_load = 1'b0;
            end
            m = (seed == 0) ? FIX : seed;
        end
        d = atl1(m_draw(m, 0, T_SLO[r], T_SHI[r]));
        n = atl1(m_draw(m, 4, T_CLO[r], T_CHI[r]));
        m = m_next(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seed_load = 1'b0;
        for (int c = 0; c < int'(d); c++) cyc(1, 0, 0, 0);
        for (int i = 1; i <= int'(n); i++) begin
            a  = atl1(m_draw(m, 2, T_ALO[r], T_AHI[r]));
            rc = m_draw(m, 1, T_RLO[r], T_RHI[r]);
            m  = m_next(m);
            for (int c = 0; c < int'(a); c++) cyc(1, 1, rc, poke && i == 1 && c == 0);
            if (i < int'(n)) begin
                g = atl1(m_draw(m, 3, T_GLO[r], T_GHI[r]));
                m = m_next(m);
                for (int c = 0; c < int'(g); c++) cyc(1, 0, 0, 0);
            end else begin
                f = atl1(m_draw(m, 5, T_FLO[r], T_FHI[r]));
                m = m_next(m);
                for (int c = 0; c < int'(f); c++) cyc(1, 0, 0, poke && c == int'(f) - 1);
            end
        end
        start = 1'b0;
        check(done === 1'b1 && busy === 1'b0 && fault_on === 1'b0 && res_code === '0,
              "R8 done pulse after safe", {done, busy, fault_on}, 3'b100);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8/R2 single done, no relaunch",
              {done, busy}, 2'b00);
    endtask

    initial begin
        longint unsigned s1;
        do_reset();
        // R1: reset state
        check(busy === 1'b0 && fault_on === 1'b0 && done === 1'b0 && res_code === '0,
              "R1 reset state", {busy, fault_on, done, res_code}, 0);

        // R5: first burst after reset draws from the reset generator value
        run_burst(1, 0, 32'd0, 0, 0);
        check(r_errs == 0, "R5 reset seed burst trace", r_errs, 0);

        // table walk
        for (int r = 0; r < NROW; r++) begin
            run_burst(r, 1, T_SEED[r], 0, 0);
            check(r_errs == 0, $sformatf("R3/R4/R6/R7 row %0d burst trace", r), r_errs, 0);
        end

        // R9: same seed reproduces the same burst
        run_burst(0, 1, 32'h00001234, 0, 0);
        s1 = r_sig;
        run_burst(0, 1, 32'h00001234, 0, 0);
        check(r_sig == s1 && r_errs == 0, "R9 repeated seed", longint'(r_sig), longint'(s1));

        // R9: zero seed behaves as the substitute constant
        run_burst(0, 1, 32'd0, 0, 0);
        s1 = r_sig;
        run_burst(0, 1, FIX, 0, 0);
        check(r_sig == s1 && r_errs == 0, "R9 zero seed substitute", longint'(r_sig), longint'(s1));

        // R9: seed load and start in the same cycle
        run_burst(1, 1, 32'hCAFE0001, 1, 0);
        check(r_errs == 0, "R9 load with start trace", r_errs, 0);

        // R2: start pulses while busy (first active cycle and last safe cycle)
        run_burst(0, 1, 32'h0BADF00D, 0, 1);
        check(r_errs == 0, "R2 start ignored while busy", r_errs, 0);

        // R2: launch raises busy on the next cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 launch busy", busy, 1);
        do_reset();
        check(busy === 1'b0 && res_code === '0, "R1 reset mid-burst", busy, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule